// File: doc/BRIEF.md
# Multi-format serial audio port

This block moves stereo audio between a three-wire serial bus (shift clock, frame clock, serial data) and parallel sample registers. Received left and right words come out together as 24-bit two's-complement values with a one-cycle valid strobe once per frame. A parallel pair presented on the transmit inputs is serialized during the following frame. Justification, word length and frame size are chosen by three configuration fields. Together they give thirteen legal formats: I2S, left justified and right justified, each at 16, 18, 20 or 24 bits with 64 shift clocks per frame, plus one 16-bit left-justified format with 32 shift clocks per frame.

The serial clocks are not used as clocks. They pass through a short synchronizer in the main clock domain, and their rising and falling transitions become single-cycle enables. A controller tracks the bit position inside each half frame and issues strobes to a datapath, which holds the shift registers and output words. The shift clock's high and low phases must each last at least three main-clock cycles.

Top module: `audio_serial_port`

## Requirements
- R1: `cfgFrame64` (bit 6 of the control word) selects the frame size. At 0 a half frame is 16 shift clocks; at 1 it is 32. The 16-clock half frame is meant for 16-bit left-justified data only.
- R2: `cfgWordLen` (control bits 5–4) sets the word length: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits. Every received word is assembled from exactly that many captured bits.
- R3: `cfgJustify` (control bits 1–0) sets the alignment: 00 left justified, 01 right justified, 10 I2S. In left and right justified modes a high frame clock marks the left channel; in I2S a low frame clock does.
- R4: A half frame begins at the first rising shift-clock edge after the frame clock toggles. The MSB is on that edge in left-justified mode and on the next one in I2S mode.
- R5: In right-justified mode the LSB is on the last rising edge of the half frame. Leading received bits are ignored, and leading transmitted bits are 0.
- R6: Received words are sign-extended from the word length to 24 bits. Bits after the word in a half frame are ignored.
- R7: `rxValid` is a one-cycle pulse, raised once per frame after the right word's last bit. `rxLeft` and `rxRight` change only with that pulse, and they carry the left and right words of the same frame.
- R8: The transmit pair is sampled on the last rising shift-clock edge of the frame and is sent during the next frame. The MSB of a word is bit word-length−1 of `txLeft`/`txRight`; higher input bits are ignored. `sdOut` changes only after a falling shift-clock edge, and it is 0 outside the word.
- R9: The reserved justification code 11 behaves as left justified.
- R10: If the frame clock does not toggle within one half frame, the port loses lock. It captures nothing, raises no `rxValid` and holds `sdOut` until the next frame-clock edge.
- R11: After reset `rxLeft`, `rxRight`, `rxValid` and `sdOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFrame64 | input | 1 | Frame size select (control bit 6) |
| cfgWordLen | input | 2 | Word length select (control bits 5–4) |
| cfgJustify | input | 2 | Justification select (control bits 1–0) |
| sclkIn | input | 1 | Serial shift clock, sampled |
| lrclkIn | input | 1 | Left/right frame clock, sampled |
| sdIn | input | 1 | Serial receive data |
| txLeft | input | 24 | Left sample to transmit |
| txRight | input | 24 | Right sample to transmit |
| rxLeft | output | 24 | Last received left sample, sign-extended |
| rxRight | output | 24 | Last received right sample, sign-extended |
| rxValid | output | 1 | One-cycle pulse when a new pair is present |
| sdOut | output | 1 | Serial transmit data |

## Verification
The embedded assertions check on every cycle that `rxValid` never lasts two cycles and that the received words move only with it. They also check that `sdOut` moves only right after a decoded falling shift-clock edge, and that each stored word was built from exactly word-length captures since the half frame began. Only the bench's scenarios can show where each bit lands in the frame for all fourteen configuration codes, and that sign extension and ignored filler bits are handled correctly. They also cover one-frame transmit latency, channel polarity per mode, and the loss and recovery of lock when the frame clock stalls.

// File: rtl/asp_pkg.sv
package asp_pkg;
  // Largest half frame in shift clocks; sets the position counter width
  localparam int FULL_HALF = 32;
  localparam int POS_W = $clog2(FULL_HALF);
  localparam int LEN_W = POS_W + 1;

  typedef enum logic [1:0] {
    JUST_LEFT  = 2'd0,
    JUST_RIGHT = 2'd1,
    JUST_I2S   = 2'd2,
    JUST_RSVD  = 2'd3
  } justE;

  // Strobes from the frame controller to the sample datapath
  typedef struct packed {
    logic             rxCapture;
    logic             rxStoreLeft;
    logic             rxStoreRight;
    logic             rxHalfStart;
    logic             txLoad;
    logic             txFall;
    logic             txInWord;
    logic             txLeftChan;
    logic [LEN_W-1:0] txBitIdx;
  } portStrobesT;
endpackage

// File: rtl/asp_frame_ctrl.sv
module asp_frame_ctrl
  import asp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgFrame64,
  input  logic [1:0]       cfgWordLen,
  input  logic [1:0]       cfgJustify,
  input  logic             sclkIn,
  input  logic             lrclkIn,
  input  logic             sdIn,
  output logic             sdSync,
  output logic [LEN_W-1:0] wordLen,
  output portStrobesT      stb
);
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] lrPipe;
  logic [SYNC_STAGES-1:0] sdPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      lrPipe   <= '0;
      sdPipe   <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
      lrPipe   <= {lrPipe[SYNC_STAGES-2:0], lrclkIn};
      sdPipe   <= {sdPipe[SYNC_STAGES-2:0], sdIn};
    end
  end

  logic sclkRise, sclkFall, lrNow;
  assign sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign sclkFall = ~sclkPipe[SYNC_STAGES-1] & sclkPipe[SYNC_STAGES];
  assign lrNow    = lrPipe[SYNC_STAGES-1];
  assign sdSync   = sdPipe[SYNC_STAGES-1];

  // Format decode
  justE just;
  logic isI2s, isRight, leftLevel;
  logic [LEN_W-1:0] halfLen, msbPos;
  assign just      = justE'(cfgJustify);
  assign isI2s     = (just == JUST_I2S);
  assign isRight   = (just == JUST_RIGHT);
  assign leftLevel = ~isI2s;
  assign halfLen   = cfgFrame64 ? LEN_W'(FULL_HALF) : LEN_W'(FULL_HALF / 2);

  always_comb begin
    case (cfgWordLen)
      2'd0:    wordLen = LEN_W'(16);
      2'd1:    wordLen = LEN_W'(18);
      2'd2:    wordLen = LEN_W'(20);
      default: wordLen = LEN_W'(24);
    endcase
  end

  assign msbPos = isI2s ? LEN_W'(1) : (isRight ? halfLen - wordLen : '0);

  // Position tracking
  logic [POS_W-1:0] pos;
  logic             lrLast, chanLeftQ, locked;
  logic             lrEdge, atHalfEnd, lockNext, curLeft;
  logic [LEN_W-1:0] curPos, rxOffset, txPos, txOffset;

  assign lrEdge    = lrNow ^ lrLast;
  assign atHalfEnd = ({1'b0, pos} >= halfLen - LEN_W'(1));
  assign lockNext  = lrEdge | (locked & ~atHalfEnd);
  assign curPos    = lrEdge ? '0 : {1'b0, pos} + LEN_W'(1);
  assign curLeft   = (lrNow == leftLevel);
  assign rxOffset  = curPos - msbPos;
  assign txPos     = atHalfEnd ? '0 : {1'b0, pos} + LEN_W'(1);
  assign txOffset  = txPos - msbPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos       <= '0;
      lrLast    <= 1'b0;
      chanLeftQ <= 1'b0;
      locked    <= 1'b0;
    end else if (sclkRise) begin
      pos       <= curPos[POS_W-1:0];
      lrLast    <= lrNow;
      chanLeftQ <= curLeft;
      locked    <= lockNext;
    end
  end

  logic rxInWord, rxLast;
  assign rxInWord = (curPos >= msbPos) && (rxOffset < wordLen);
  assign rxLast   = (rxOffset == wordLen - LEN_W'(1));

  always_comb begin
    stb              = '0;
    stb.rxCapture    = sclkRise & lockNext & rxInWord;
    stb.rxStoreLeft  = stb.rxCapture & rxLast & curLeft;
    stb.rxStoreRight = stb.rxCapture & rxLast & ~curLeft;
    stb.rxHalfStart  = sclkRise & lrEdge;
    stb.txLoad       = sclkRise & lockNext & ~curLeft & (curPos == halfLen - LEN_W'(1));
    stb.txFall       = sclkFall & locked;
    stb.txInWord     = (txPos >= msbPos) && (txOffset < wordLen);
    stb.txLeftChan   = atHalfEnd ? ~chanLeftQ : chanLeftQ;
    stb.txBitIdx     = wordLen - LEN_W'(1) - txOffset;
  end
endmodule

// File: rtl/asp_sample_path.sv
module asp_sample_path
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobesT         stb,
  input  logic [LEN_W-1:0]    wordLen,
  input  logic                sdSync,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid,
  output logic                sdOut
);
  function automatic logic [SAMPLE_W-1:0] signExtend(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [LEN_W-1:0] len);
    logic [SAMPLE_W-1:0] res;
    logic signBit;
    signBit = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++)
      if (int'(len) - 1 == i) signBit = raw[i];
    for (int i = 0; i < SAMPLE_W; i++)
      res[i] = (i < int'(len)) ? raw[i] : signBit;
    return res;
  endfunction

  // Receive side
  logic [SAMPLE_W-2:0] rxShift;
  logic [SAMPLE_W-1:0] rxShiftNext, leftHold;
  assign rxShiftNext = {rxShift, sdSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      leftHold <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.rxCapture) rxShift <= rxShiftNext[SAMPLE_W-2:0];
      if (stb.rxStoreLeft) leftHold <= signExtend(rxShiftNext, wordLen);
      if (stb.rxStoreRight) begin
        rxLeft  <= leftHold;
        rxRight <= signExtend(rxShiftNext, wordLen);
        rxValid <= 1'b1;
      end
    end
  end

  // Transmit side
  logic [SAMPLE_W-1:0] txLeftQ, txRightQ, txWord;
  logic txBit;
  assign txWord = stb.txLeftChan ? txLeftQ : txRightQ;

  always_comb begin
    txBit = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++)
      if (stb.txBitIdx == LEN_W'(i)) txBit = txWord[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLeftQ  <= '0;
      txRightQ <= '0;
      sdOut    <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txLeftQ  <= txLeft;
        txRightQ <= txRight;
      end
      if (stb.txFall) sdOut <= stb.txInWord & txBit;
    end
  end

  // Capture counter kept for the word-length check only
  logic [LEN_W-1:0] capCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capCnt <= '0;
    else if (stb.rxHalfStart) capCnt <= stb.rxCapture ? LEN_W'(1) : '0;
    else if (stb.rxCapture) capCnt <= capCnt + LEN_W'(1);
  end

  AST_WORD_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxStoreLeft || stb.rxStoreRight) |-> capCnt == wordLen - LEN_W'(1)); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxLeft) && $stable(rxRight))); // R7

  AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.txFall) |-> $stable(sdOut)); // R8
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgFrame64,
  input  logic [1:0]          cfgWordLen,
  input  logic [1:0]          cfgJustify,
  input  logic                sclkIn,
  input  logic                lrclkIn,
  input  logic                sdIn,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid,
  output logic                sdOut
);
  portStrobesT      stb;
  logic [LEN_W-1:0] wordLen;
  logic             sdSync;

  asp_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgFrame64(cfgFrame64), .cfgWordLen(cfgWordLen), .cfgJustify(cfgJustify),
    .sclkIn(sclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .sdSync(sdSync), .wordLen(wordLen), .stb(stb)
  );

  asp_sample_path #(.SAMPLE_W(SAMPLE_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .wordLen(wordLen), .sdSync(sdSync),
    .txLeft(txLeft), .txRight(txRight),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid), .sdOut(sdOut)
  );
endmodule

// File: tb/audio_serial_port_test.sv
`timescale 1ns/1ps
module audio_serial_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cfgFrame64, sclkIn, lrclkIn, sdIn, rxValid, sdOut;
  logic [1:0] cfgWordLen, cfgJustify;
  logic [23:0] txLeft, txRight, rxLeft, rxRight;

  audio_serial_port uut (
    .clk(clk), .rstN(rstN), .cfgFrame64(cfgFrame64), .cfgWordLen(cfgWordLen),
    .cfgJustify(cfgJustify), .sclkIn(sclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .txLeft(txLeft), .txRight(txRight), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid), .sdOut(sdOut)
  );

  int checks = 0, errors = 0, validCnt = 0;
  logic [23:0] gotL, gotR, prevTl, prevTr;
  int wLen, hLen, msb;
  bit leftLvl;
  string fmtTag;

  always @(negedge clk) if (rxValid) begin
    validCnt++;
    gotL = rxLeft;
    gotR = rxRight;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Code 0 is the short-frame 16-bit left-justified format, 1..12 the long-frame
  // formats, 13 the reserved justification code.
  task automatic setMode(input int k);
    if (k == 0) begin
      cfgFrame64 = 1'b0; cfgWordLen = 2'd0; cfgJustify = 2'd0;
    end else if (k == 13) begin
      cfgFrame64 = 1'b1; cfgWordLen = 2'd0; cfgJustify = 2'd3;
    end else begin
      cfgFrame64 = 1'b1; cfgWordLen = 2'((k - 1) / 3); cfgJustify = 2'((k - 1) % 3);
    end
    wLen = (cfgWordLen == 2'd3) ? 24 : 16 + 2 * int'(cfgWordLen);
    hLen = cfgFrame64 ? 32 : 16;
    msb = (cfgJustify == 2'd2) ? 1 : (cfgJustify == 2'd1) ? hLen - wLen : 0;
    leftLvl = (cfgJustify != 2'd2);
    fmtTag = (k == 13) ? "R9" : (cfgJustify == 2'd1) ? "R5" : "R4";
  endtask

  function automatic bit bitAt(input logic [23:0] word, input int p, input bit filler);
    int idx = p - msb;
    if (idx >= 0 && idx < wLen) return word[wLen - 1 - idx];
    return filler;
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v);
    logic [23:0] m = 24'hFFFFFF >> (24 - wLen);
    logic [23:0] r = v & m;
    if (r[wLen - 1]) r = r | ~m;
    return r;
  endfunction

  task automatic runFrame(input logic [23:0] rl, input logic [23:0] rr,
                          input logic [23:0] tl, input logic [23:0] tr,
                          input bit doCheck, input bit stuck);
    logic [31:0] vec [2];
    logic [31:0] expv [2];
    vec[0] = '0; vec[1] = '0; expv[0] = '0; expv[1] = '0;
    @(negedge clk);
    txLeft = tl; txRight = tr;
    validCnt = 0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < hLen; p++) begin
        @(negedge clk);
        sclkIn = 1'b0;
        lrclkIn = (stuck || ch == 0) ? leftLvl : ~leftLvl;
        sdIn = bitAt(ch == 0 ? rl : rr, p, 1'b1);
        repeat (4) @(negedge clk);
        vec[ch][p] = sdOut;
        expv[ch][p] = bitAt(ch == 0 ? prevTl : prevTr, p, 1'b0);
        sclkIn = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
    if (doCheck && stuck) begin
      chk(validCnt == 0, "R10 no valid while frame clock stalls", validCnt, 0);
    end else if (doCheck) begin
      chk(validCnt == 1, {"R7 one valid per frame ", fmtTag}, validCnt, 1);
      chk(gotL == sext(rl), {"R6 rxLeft sign-extended ", fmtTag}, gotL, sext(rl));
      chk(gotR == sext(rr), {"R6 rxRight sign-extended ", fmtTag}, gotR, sext(rr));
      chk(vec[0] == expv[0], {"R8 left serial bits ", fmtTag}, vec[0], expv[0]);
      chk(vec[1] == expv[1], {"R8 right serial bits ", fmtTag}, vec[1], expv[1]);
    end
    prevTl = tl; prevTr = tr;
  endtask

  function automatic logic [23:0] pat(input int f, input int k, input bit right);
    logic [23:0] m = 24'hFFFFFF >> (24 - wLen);
    logic [23:0] v;
    case (f)
      0: v = right ? (m >> 1) : (24'h1 << (wLen - 1));
      1: v = right ? 24'h0 : m;
      default: v = (24'h5A3C96 * 24'(f + k + 1)) ^ (right ? 24'hC3A5F0 : 24'h0);
    endcase
    return v;
  endfunction

  initial begin
    rstN = 1'b0; sclkIn = 1'b1; lrclkIn = 1'b0; sdIn = 1'b0;
    txLeft = '0; txRight = '0; prevTl = '0; prevTr = '0;
    setMode(0);
    repeat (5) @(negedge clk);
    chk(rxLeft == 24'h0, "R11 rxLeft reset", rxLeft, 0);
    chk(rxRight == 24'h0, "R11 rxRight reset", rxRight, 0);
    chk(rxValid == 1'b0, "R11 rxValid reset", rxValid, 0);
    chk(sdOut == 1'b0, "R11 sdOut reset", sdOut, 0);
    rstN = 1'b1;
    // R1 R2 R3: sweep all fourteen configuration codes
    for (int k = 0; k < 14; k++) begin
      setMode(k);
      runFrame(24'h123456, 24'h654321, pat(0, k, 0) ^ 24'hF0F0F0, pat(0, k, 1) ^ 24'h0F0F0F, 0, 0);
      for (int f = 0; f < 4; f++) begin
        logic [23:0] m = 24'hFFFFFF >> (24 - wLen);
        logic [23:0] tl = (pat((f + 1) % 4, k, 0) ^ 24'h0F0F0F) | ~m;
        logic [23:0] tr = (pat((f + 1) % 4, k, 1) ^ 24'h3C3C3C) | ~m;
        runFrame(pat(f, k, 0), pat(f, k, 1), tl, tr, 1, 0);
      end
    end
    // R10: stall the frame clock in right-justified 16-bit mode, then recover
    setMode(2);
    runFrame(24'h0, 24'h0, 24'h00A5A5, 24'h005A5A, 0, 0);
    runFrame(24'h001234, 24'h004321, 24'h001111, 24'h002222, 1, 1);
    runFrame(24'h0, 24'h0, 24'h007777, 24'h008888, 0, 0);
    runFrame(24'h00BEEF, 24'h007ACE, 24'h003333, 24'h004444, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule